// File: doc/BRIEF.md
# CEC Receive Frame Queue

This block sits between a bit-level CEC receiver and the register bank that software reads. Each complete frame the receiver hands over (one header byte, one opcode byte, up to fifteen operand bytes, and a flag saying whether the frame arrived damaged) is kept whole in a small queue of frame slots. Software always sees the oldest stored frame through a fixed window of byte-wide, word-spaced registers. It also sees a packed status word that gives that frame's operand count, how many frames are waiting, and the frame's error flag.

Software takes a frame out by writing a self-clearing pop bit, or throws all frames away with a flush bit. A level output tells the interrupt logic that frames are waiting. A one-cycle event output reports that a frame arrived while every slot was occupied; that frame is lost and the stored frames are untouched.

Top module: `cec_rx_frame_queue`

## Requirements
- R1: A push stores the frame. Up to DEPTH (default 4) frames are held, and the head registers always show the oldest frame, so frames leave in arrival order.
- R2: The status word at byte offset 0x00 packs the head frame's operand count in bits [3:0], the number of stored frames in bits [6:4] and the head frame's error flag in bit 7. It reads 0x00 when the queue is empty.
- R3: The head header reads at 0x08 and the head opcode at 0x0C. Operand i (0..14) reads at 0x10 + 4*i, taken from push_ops bits [8*i+7:8*i]. An operand index at or above the head's operand count reads 0, and all of these registers read 0 when the queue is empty.
- R4: A write to the control register at 0x04 with bit 0 set and bit 1 clear removes the head frame at the next clock edge. The control register reads 0x01 for the one cycle between the write and the removal, then reads 0x00. A pop with an empty queue changes nothing.
- R5: A write to 0x04 with bit 1 set (for example 0x03) discards every stored frame at the next clock edge. The control register reads the written bits for that one cycle, then 0x00.
- R6: A frame pushed with its error flag set is stored and counted like any other frame, and it leaves only through a pop or a flush.
- R7: irq_not_empty is high exactly when at least one frame is stored.
- R8: A push while all DEPTH slots are occupied, with no pop or flush taking effect at that edge, is dropped. The stored frames stay unchanged, and evt_overrun is high for the one cycle after that edge.
- R9: A push at the edge where a pop takes effect on a full queue is accepted without an overrun. A push at the edge where a flush takes effect survives as the only stored frame.
- R10: Reads at unaligned or unmapped offsets return 0, and writes to any offset other than 0x04 have no effect.
- R11: While reset is asserted the queue is empty, the control register reads 0 and both event outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Receiver offers one complete frame this cycle |
| push_hdr | input | 8 | Header byte of the offered frame |
| push_opc | input | 8 | Opcode byte of the offered frame |
| push_nops | input | 4 | Number of valid operand bytes (0..15) |
| push_ops | input | 120 | Operand bytes, operand i in bits [8*i+7:8*i] |
| push_err | input | 1 | Offered frame was received with an error |
| reg_addr | input | 7 | Byte offset of the register access |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr, combinational |
| irq_not_empty | output | 1 | At least one frame is stored |
| evt_overrun | output | 1 | One-cycle pulse after a dropped frame |

## Verification
Two collisions matter. The first is a frame arriving from the receiver at the same edge where a pop or a flush ordered by software takes effect. The second is a push against a full queue that may or may not be rescued by a pop landing at the same edge. The bench provokes both by issuing the control write and then pushing in the very next cycle, against a full queue and against a partly filled one. A queue-based model in the bench decides from the requirements whether the frame is kept, where it lands in order, and whether the overrun event fires. Every cycle the bench compares that model with the status word, the head window, the not-empty level and the overrun pulse.

// File: rtl/cec_rxq_pkg.sv
package cec_rxq_pkg;

  localparam int OPS_MAX = 15;
  localparam int NOPS_W  = 4;

  // word indices (byte offset / 4) of the register window
  localparam int W_STAT = 0;
  localparam int W_CTRL = 1;
  localparam int W_HDR  = 2;
  localparam int W_OPC  = 3;
  localparam int W_OPS  = 4;

  typedef struct packed {
    logic                   err;
    logic [NOPS_W-1:0]      nops;
    logic [7:0]             hdr;
    logic [7:0]             opc;
    logic [OPS_MAX*8-1:0]   ops;
  } rx_frame_t;

endpackage

// File: rtl/cec_rxq_store.sv
module cec_rxq_store
  import cec_rxq_pkg::*;
#(
  parameter  int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  rx_frame_t        push_frame,
  input  logic             pop_go,
  input  logic             flush_go,
  output rx_frame_t        head_frame,
  output logic [CNT_W-1:0] count_o,
  output logic             overrun_o
);

  rx_frame_t        slot_q [DEPTH];
  logic [PTR_W-1:0] rd_q, rd_n, wr_q, wr_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, cnt_base;
  logic             ovr_q, ovr_n;
  logic             do_pop, has_room, accept;

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    do_pop   = pop_go && (cnt_q != '0);
    has_room = (cnt_q != CNT_W'(DEPTH)) || do_pop || flush_go;
    accept   = push_valid && has_room;
    ovr_n    = push_valid && !has_room;

    rd_n = rd_q;
    if (flush_go)    rd_n = wr_q;
    else if (do_pop) rd_n = step_ptr(rd_q);

    wr_n = accept ? step_ptr(wr_q) : wr_q;

    if (flush_go)    cnt_base = '0;
    else if (do_pop) cnt_base = cnt_q - 1'b1;
    else             cnt_base = cnt_q;
    cnt_n = accept ? cnt_base + 1'b1 : cnt_base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      rd_q  <= rd_n;
      wr_q  <= wr_n;
      cnt_q <= cnt_n;
      ovr_q <= ovr_n;
    end
  end

  // frame storage: data only, no reset, written with an explicit enable
  always_ff @(posedge clk) begin
    if (accept) slot_q[wr_q] <= push_frame;
  end

  assign head_frame = slot_q[rd_q];
  assign count_o    = cnt_q;
  assign overrun_o  = ovr_q;

endmodule

// File: rtl/cec_rxq_ctrl.sv
module cec_rxq_ctrl
  import cec_rxq_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [1:0]    ctrl_o,
  output logic          pop_go,
  output logic          flush_go
);

  logic [1:0] ctrl_q, ctrl_n;
  logic       ctrl_sel;

  always_comb begin
    ctrl_sel = reg_wr && (reg_addr == AW'(W_CTRL * 4));
    // a written action lives for exactly one cycle, then clears itself
    ctrl_n   = ctrl_sel ? reg_wdata[1:0] : 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= 2'b00;
    else        ctrl_q <= ctrl_n;
  end

  assign ctrl_o   = ctrl_q;
  assign flush_go = ctrl_q[1];
  assign pop_go   = ctrl_q[0] && !ctrl_q[1];

endmodule

// File: rtl/cec_rxq_regs.sv
module cec_rxq_regs
  import cec_rxq_pkg::*;
#(
  parameter  int AW    = 7,
  parameter  int CNT_W = 3,
  localparam int WW    = AW - 2
) (
  input  logic [AW-1:0]    reg_addr,
  input  rx_frame_t        head_frame,
  input  logic [CNT_W-1:0] count_i,
  input  logic [1:0]       ctrl_i,
  output logic [7:0]       rdata
);

  logic [7:0]    op_b [OPS_MAX];
  logic [WW-1:0] word, idx;
  logic          has_head;

  for (genvar i = 0; i < OPS_MAX; i++) begin : g_opb
    assign op_b[i] = head_frame.ops[8*i +: 8];
  end

  always_comb begin
    word     = reg_addr[AW-1:2];
    idx      = word - WW'(W_OPS);
    has_head = (count_i != '0);
    rdata    = 8'h00;
    if (reg_addr[1:0] == 2'b00) begin
      if (word == WW'(W_CTRL)) begin
        rdata = {6'b0, ctrl_i};
      end else if (has_head) begin
        if (word == WW'(W_STAT))
          rdata = {head_frame.err, 3'(count_i), head_frame.nops};
        else if (word == WW'(W_HDR))
          rdata = head_frame.hdr;
        else if (word == WW'(W_OPC))
          rdata = head_frame.opc;
        else if ((word >= WW'(W_OPS)) && (word < WW'(W_OPS + OPS_MAX)) &&
                 (idx < WW'(head_frame.nops)))
          rdata = op_b[idx[3:0]];
      end
    end
  end

endmodule

// File: rtl/cec_rx_frame_queue.sv
module cec_rx_frame_queue
  import cec_rxq_pkg::*;
#(
  parameter  int DEPTH = 4,
  parameter  int AW    = 7,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_valid,
  input  logic [7:0]         push_hdr,
  input  logic [7:0]         push_opc,
  input  logic [NOPS_W-1:0]  push_nops,
  input  logic [OPS_MAX*8-1:0] push_ops,
  input  logic               push_err,
  input  logic [AW-1:0]      reg_addr,
  input  logic               reg_wr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic               irq_not_empty,
  output logic               evt_overrun
);

  rx_frame_t        in_frame, head_frame;
  logic [CNT_W-1:0] q_count;
  logic [1:0]       q_ctrl;
  logic             pop_go, flush_go;

  assign in_frame = '{err: push_err, nops: push_nops, hdr: push_hdr,
                      opc: push_opc, ops: push_ops};

  cec_rxq_ctrl #(.AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ctrl_o    (q_ctrl),
    .pop_go    (pop_go),
    .flush_go  (flush_go)
  );

  cec_rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .push_frame (in_frame),
    .pop_go     (pop_go),
    .flush_go   (flush_go),
    .head_frame (head_frame),
    .count_o    (q_count),
    .overrun_o  (evt_overrun)
  );

  cec_rxq_regs #(.AW(AW), .CNT_W(CNT_W)) u_regs (
    .reg_addr   (reg_addr),
    .head_frame (head_frame),
    .count_i    (q_count),
    .ctrl_i     (q_ctrl),
    .rdata      (reg_rdata)
  );

  assign irq_not_empty = (q_count != '0);

endmodule

// File: rtl/cec_rxq_chk.sv
module cec_rxq_chk #(
  parameter int DEPTH = 4,
  parameter int AW    = 7,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_valid,
  input logic             reg_wr,
  input logic [AW-1:0]    reg_addr,
  input logic [CNT_W-1:0] q_count,
  input logic [1:0]       q_ctrl,
  input logic             irq_not_empty,
  input logic             evt_overrun
);

  logic ctrl_write;
  assign ctrl_write = reg_wr && (reg_addr == AW'(4));

  // R1: occupancy never exceeds the number of slots
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CNT_W'(DEPTH));

  // R7: the not-empty level can only rise after a frame was offered
  a_r7_rise_needs_push: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_not_empty) |-> $past(push_valid));

  // R8: an overrun pulse follows an edge where the queue was and stays full
  a_r8_overrun_full: assert property (@(posedge clk) disable iff (!rst_n)
    evt_overrun |-> ($past(q_count) == CNT_W'(DEPTH)) && (q_count == CNT_W'(DEPTH)));

  // R4: the control bits clear themselves one cycle after being written
  a_r4_ctrl_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    (q_ctrl != 2'b00 && !ctrl_write) |=> (q_ctrl == 2'b00));

  // R4: a pop on a non-empty queue without a push removes exactly one frame
  a_r4_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
    (q_ctrl == 2'b01 && q_count != '0 && !push_valid) |=>
      (q_count == $past(q_count) - 1'b1));

  // R5: a flush without a push leaves the queue empty
  a_r5_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (q_ctrl[1] && !push_valid) |=> (q_count == '0));

endmodule

bind cec_rx_frame_queue cec_rxq_chk #(.DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .push_valid    (push_valid),
  .reg_wr        (reg_wr),
  .reg_addr      (reg_addr),
  .q_count       (q_count),
  .q_ctrl        (q_ctrl),
  .irq_not_empty (irq_not_empty),
  .evt_overrun   (evt_overrun)
);

// File: tb/sim_cec_rx_frame_queue.sv
`timescale 1ns/1ps
module sim_cec_rx_frame_queue;
  import cec_rxq_pkg::*;

  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       push_valid;
  rx_frame_t  pf;
  logic [6:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq_not_empty;
  logic       evt_overrun;

  int    chk_n  = 0;
  int    fail_n = 0;
  string scen   = "R11";

  always #2 clk = ~clk;

  cec_rx_frame_queue #(.DEPTH(DEPTH), .AW(7)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .push_valid    (push_valid),
    .push_hdr      (pf.hdr),
    .push_opc      (pf.opc),
    .push_nops     (pf.nops),
    .push_ops      (pf.ops),
    .push_err      (pf.err),
    .reg_addr      (reg_addr),
    .reg_wr        (reg_wr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .irq_not_empty (irq_not_empty),
    .evt_overrun   (evt_overrun)
  );

  // ---------------- behavioural reference model ----------------
  rx_frame_t  mq[$];
  logic [1:0] ctrl_m;
  bit         ovr_m;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete();
      ctrl_m = 2'b00;
      ovr_m  = 1'b0;
    end else begin
      bit do_flush, do_pop, room;
      do_flush = ctrl_m[1];
      do_pop   = !ctrl_m[1] && ctrl_m[0] && (mq.size() > 0);
      room     = (mq.size() < DEPTH) || do_pop || do_flush;
      if (do_flush)    mq.delete();
      else if (do_pop) void'(mq.pop_front());
      ovr_m = 1'b0;
      if (push_valid) begin
        if (room) mq.push_back(pf);
        else      ovr_m = 1'b1;
      end
      ctrl_m = (reg_wr && reg_addr == 7'h04) ? reg_wdata[1:0] : 2'b00;
    end
  end

  function automatic logic [7:0] exp_rd(input logic [6:0] a);
    int        w;
    rx_frame_t h;
    w = int'(a) / 4;
    if (a[1:0] != 2'b00) return 8'h00;
    if (w == 1) return {6'b0, ctrl_m};
    if (mq.size() == 0) return 8'h00;
    h = mq[0];
    if (w == 0) return {h.err, 3'(mq.size()), h.nops};
    if (w == 2) return h.hdr;
    if (w == 3) return h.opc;
    if (w >= 4 && w < 19 && (w - 4) < int'(h.nops)) return h.ops[8*(w-4) +: 8];
    return 8'h00;
  endfunction

  function automatic string tag_of(input logic [6:0] a);
    int w;
    w = int'(a) / 4;
    if (a[1:0] != 2'b00 || w > 18) return "R10";
    if (w == 0) return "R2";
    if (w == 1) return "R4/R5";
    return "R3";
  endfunction

  task automatic check(input string req, input string what, input int got, input int exp);
    chk_n++;
    if (got !== exp) begin
      fail_n++;
      $display("FAIL %s (scenario %s) %s: got 0x%0h expected 0x%0h", req, scen, what, got, exp);
    end
  endtask

  task automatic compare();
    check(tag_of(reg_addr), $sformatf("rdata @0x%0h", reg_addr), int'(reg_rdata), int'(exp_rd(reg_addr)));
    check("R7", "irq_not_empty", int'(irq_not_empty), int'(mq.size() > 0));
    check("R8", "evt_overrun", int'(evt_overrun), int'(ovr_m));
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
    push_valid = 1'b0;
    reg_wr     = 1'b0;
    reg_wdata  = 8'h00;
  endtask

  task automatic push(input rx_frame_t f);
    tick();
    pf         = f;
    push_valid = 1'b1;
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    tick();
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
  endtask

  task automatic scan();
    for (int a = 0; a < 80; a++) begin
      tick();
      reg_addr = 7'(a);
    end
  endtask

  function automatic rx_frame_t mk(input int s, input int n, input bit e);
    rx_frame_t f;
    f.hdr  = 8'(s * 17 + 3);
    f.opc  = 8'(s * 29 + 1);
    f.nops = 4'(n);
    f.err  = e;
    for (int i = 0; i < OPS_MAX; i++) f.ops[8*i +: 8] = 8'(s * 7 + i * 13 + 5);
    return f;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", chk_n, fail_n);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fail_n++;
    $display("FAIL R1 watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    rst_n      = 1'b0;
    push_valid = 1'b0;
    pf         = mk(0, 0, 1'b0);
    reg_addr   = 7'h00;
    reg_wr     = 1'b0;
    reg_wdata  = 8'h00;
    // R11: reset state
    repeat (3) @(negedge clk);
    check("R11", "status in reset", int'(reg_rdata), 0);
    check("R11", "irq in reset", int'(irq_not_empty), 0);
    check("R11", "overrun in reset", int'(evt_overrun), 0);
    reg_addr = 7'h04;
    @(negedge clk);
    check("R11", "ctrl in reset", int'(reg_rdata), 0);
    rst_n = 1'b1;

    // R1 ordering, R2 status, R3 window (operand counts 0, 5, 15)
    scen = "R1";
    push(mk(1, 0, 1'b0));
    push(mk(2, 5, 1'b0));
    push(mk(3, 15, 1'b0));
    scan();

    // R4 pop: control reads back, head advances
    scen = "R4";
    wr(7'h04, 8'h01);
    tick(); reg_addr = 7'h04;
    scan();
    wr(7'h04, 8'h01);
    scan();

    // R8 fill to DEPTH, then a dropped push
    scen = "R8";
    push(mk(4, 2, 1'b0));
    push(mk(5, 7, 1'b0));
    push(mk(6, 9, 1'b0));
    push(mk(7, 1, 1'b0));
    tick(); reg_addr = 7'h00;
    scan();

    // R9 push at the edge where a pop lands on a full queue
    scen = "R9";
    wr(7'h04, 8'h01);
    push(mk(8, 3, 1'b0));
    scan();

    // R5 flush of a full queue
    scen = "R5";
    wr(7'h04, 8'h03);
    tick(); reg_addr = 7'h04;
    scan();

    // R6 errored frames stored, popped like others
    scen = "R6";
    push(mk(9, 4, 1'b1));
    push(mk(10, 6, 1'b0));
    scan();
    wr(7'h04, 8'h01);
    scan();

    // R9 push at the edge where a flush lands
    scen = "R9";
    push(mk(11, 2, 1'b0));
    wr(7'h04, 8'h03);
    push(mk(12, 8, 1'b1));
    scan();

    // R10 writes elsewhere and unaligned writes ignored
    scen = "R10";
    wr(7'h00, 8'h03);
    wr(7'h05, 8'h03);
    wr(7'h08, 8'h01);
    wr(7'h7C, 8'h03);
    scan();

    // R4 pop on empty queue has no effect
    scen = "R4";
    wr(7'h04, 8'h01);
    scan();
    wr(7'h04, 8'h01);
    wr(7'h04, 8'h01);
    scan();
    tick();
    finish_run();
  end

endmodule